// File: doc/BRIEF.md
# Monitor Channel Last-Look Receiver

This block is the receiving end of a byte-wide monitor channel that is carried once per frame. On every frame strobe it looks at the byte on the channel and at the far transmitter's active-low transmit flag. A byte is taken only after the same value has arrived in two frames in a row while the transmit flag is active. This last-look comparison screens out bytes corrupted on the line. The block then acknowledges the byte by pulling its active-low acknowledge flag to 0. Accepted bytes are kept in a small command store. When the end of the message is seen, they are released in one burst on a valid interface, with first and last markers.

An abort empties the store, and none of its bytes are ever released. An abort is raised in two cases. In the first, the transmitter drops its flag in the middle of a byte. In the second, the receiver refuses a byte by holding its acknowledge inactive for two frames. It refuses a byte while its own side is transmitting or while the store is full. The controller is a single state machine with these states:

- IDLE: no message in progress.
- FIRST: one sample is held and the next is awaited.
- ACKED: the acknowledge flag is driven.
- GAP: one idle frame has followed an acknowledged byte.
- HOLD: a byte has been refused.
- ABORT: one cycle, which clears the store.
- DRAIN: the store is released.

Its transitions are:

- IDLE→FIRST: a byte arrives.
- FIRST→FIRST: a sample differs from the previous one.
- FIRST→ACKED: a sample matches the previous one.
- ACKED→GAP: the transmit flag goes inactive.
- ACKED→FIRST: a new value arrives.
- GAP→FIRST: the next byte arrives.
- GAP→DRAIN: a second idle frame arrives.
- IDLE, FIRST, ACKED or GAP→HOLD: a byte arrives while the block is blocked.
- FIRST→ABORT: the transmit flag is dropped.
- HOLD→ABORT: the next strobe arrives.
- ABORT→IDLE and DRAIN→IDLE: these are automatic.

Frame strobes are assumed to be at least STORE_DEPTH+2 clock cycles apart. Strobes that arrive during ABORT or DRAIN are ignored.

Top module: `monrx_lastlook`

## Requirements
- R1: After reset, ack_n is 1, msg_valid is 0 and abort_pulse is 0.
- R2: A byte is accepted, and ack_n reads 0 from the clock after the strobe, only when the same value was sampled at two consecutive strobes, both with tx_act_n = 0. A single sample leaves ack_n at 1.
- R3: If two successive samples differ, nothing is accepted. Each new sample is compared with the one before it until two equal samples arrive.
- R4: ack_n stays 0 while the acknowledged byte repeats. It returns to 1 after a strobe that has tx_act_n = 1. It also returns to 1 after a strobe that carries a different value, and that value counts as the first sample of the next byte.
- R5: A message ends at the second consecutive strobe that has tx_act_n = 1 while ack_n = 1. A single such strobe between bytes keeps the message open. Idle strobes with no message in progress produce no output.
- R6: At end of message, the stored bytes are output in arrival order on consecutive cycles, starting the cycle after the strobe, with msg_valid = 1. msg_first is 1 only on the first byte and msg_last is 1 only on the last byte.
- R7: If tx_act_n = 1 arrives after a first sample but before the byte is accepted, abort_pulse is 1 for exactly one cycle after that strobe.
- R8: An abort empties the store. No byte accepted before the abort is ever output, and the next message starts with msg_first on its own first byte.
- R9: While local_tx_busy = 1, an arriving byte is not acknowledged. The next strobe then raises abort_pulse.
- R10: When STORE_DEPTH bytes are stored and a further byte arrives, the new byte is not acknowledged. The next strobe aborts and nothing is output.
- R11: Between strobes, ack_n does not change, whatever the channel inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_stb | input | 1 | One-cycle pulse, once per frame |
| rx_byte | input | DATA_W | Monitor byte for this frame |
| tx_act_n | input | 1 | Far transmitter's flag, 0 = sending |
| local_tx_busy | input | 1 | Own side is transmitting; blocks reception |
| ack_n | output | 1 | Acknowledge flag, 0 = byte accepted |
| msg_valid | output | 1 | Output byte is valid |
| msg_data | output | DATA_W | Output byte |
| msg_first | output | 1 | First byte of the message |
| msg_last | output | 1 | Last byte of the message |
| abort_pulse | output | 1 | One-cycle abort indication |

## Verification
The bench uses value sequences that differ at every frame before settling. A receiver that took the first sample, or that compared against a stale value, would acknowledge too early. Messages that run on with a new value before any idle frame check that the acknowledge is released and that the new value is not dropped. A lone idle frame between bytes checks that the message stays open, where a design that ended messages too soon would split it in two. Three cases are aimed at the store: an abort in the middle of a message, a refusal while busy, and a fifth byte into a four-deep store. A store that survived the abort would leak stale bytes into the next message, or would move its first marker to the wrong byte.

// File: rtl/monrx_pkg.sv
package monrx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FIRST,
        ST_ACKED,
        ST_GAP,
        ST_HOLD,
        ST_ABORT,
        ST_DRAIN
    } monrx_state_e;
endpackage

// File: rtl/monrx_store.sv
module monrx_store #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         full,
    output logic         empty,
    output logic         last_one
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else if (clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            cnt <= cnt + CW'(push) - CW'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (push && !clear) mem[wr_ptr] <= push_data;
    end

    assign head     = mem[rd_ptr];
    assign full     = (cnt == CW'(DEPTH));
    assign empty    = (cnt == '0);
    assign last_one = (cnt == CW'(1));

    // R10: the controller never writes into a full store
    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // R6: draining never reads an empty store
    p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    // R8: a clear leaves the store empty
    p_clear_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> empty);
endmodule

// File: rtl/monrx_fsm.sv
module monrx_fsm
    import monrx_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         frame_stb,
    input  logic [W-1:0] rx_byte,
    input  logic         tx_act_n,
    input  logic         local_tx_busy,
    input  logic         st_full,
    input  logic         st_empty,
    input  logic         st_last,
    output logic         push,
    output logic         pop,
    output logic         clear,
    output logic         ack_n,
    output logic         msg_valid,
    output logic         msg_first,
    output logic         msg_last,
    output logic         abort_pulse
);
    monrx_state_e state_q, state_d;
    logic [W-1:0] prev_q;
    logic         cap;
    logic         first_q;

    logic tx_on, blocked, same;
    assign tx_on   = !tx_act_n;
    assign blocked = local_tx_busy | st_full;
    assign same    = (rx_byte == prev_q);

    // state register and sample holder
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            prev_q  <= '0;
            first_q <= 1'b1;
        end else begin
            state_q <= state_d;
            if (cap) prev_q <= rx_byte;
            first_q <= (state_q != ST_DRAIN);
        end
    end

    // transitions, evaluated on frame strobes
    always_comb begin
        state_d = state_q;
        cap     = 1'b0;
        push    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (frame_stb && tx_on) begin
                    if (blocked) state_d = ST_HOLD;
                    else begin cap = 1'b1; state_d = ST_FIRST; end
                end
            end
            ST_FIRST: begin
                if (frame_stb) begin
                    if (!tx_on)       state_d = ST_ABORT;
                    else if (blocked) state_d = ST_HOLD;
                    else if (same) begin push = 1'b1; state_d = ST_ACKED; end
                    else cap = 1'b1;
                end
            end
            ST_ACKED: begin
                if (frame_stb) begin
                    if (!tx_on) state_d = ST_GAP;
                    else if (!same) begin
                        if (blocked) state_d = ST_HOLD;
                        else begin cap = 1'b1; state_d = ST_FIRST; end
                    end
                end
            end
            ST_GAP: begin
                if (frame_stb) begin
                    if (!tx_on)       state_d = st_empty ? ST_IDLE : ST_DRAIN;
                    else if (blocked) state_d = ST_HOLD;
                    else begin cap = 1'b1; state_d = ST_FIRST; end
                end
            end
            ST_HOLD:  if (frame_stb) state_d = ST_ABORT;
            ST_ABORT: state_d = ST_IDLE;
            ST_DRAIN: if (st_last) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs from state
    always_comb begin
        ack_n       = 1'b1;
        msg_valid   = 1'b0;
        pop         = 1'b0;
        clear       = 1'b0;
        abort_pulse = 1'b0;
        msg_first   = 1'b0;
        msg_last    = 1'b0;
        unique case (state_q)
            ST_ACKED: ack_n = 1'b0;
            ST_ABORT: begin clear = 1'b1; abort_pulse = 1'b1; end
            ST_DRAIN: begin
                msg_valid = 1'b1;
                pop       = 1'b1;
                msg_first = first_q;
                msg_last  = st_last;
            end
            default: ;
        endcase
    end

    // R11: the acknowledge moves only after a strobe
    p_ack_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_stb |=> $stable(ack_n));
    // R2: an acknowledge starts only after a strobe with the transmitter active
    p_ack_needs_tx_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_n) |-> ($past(frame_stb) && !$past(tx_act_n)));
    // R7: the abort indication lasts a single cycle
    p_abort_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse |=> !abort_pulse);
    // R6: markers appear only on valid bytes
    p_marks_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_first || msg_last) |-> msg_valid);
endmodule

// File: rtl/monrx_lastlook.sv
module monrx_lastlook #(
    parameter int DATA_W      = 8,
    parameter int STORE_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_stb,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              tx_act_n,
    input  logic              local_tx_busy,
    output logic              ack_n,
    output logic              msg_valid,
    output logic [DATA_W-1:0] msg_data,
    output logic              msg_first,
    output logic              msg_last,
    output logic              abort_pulse
);
    logic push, pop, clear, st_full, st_empty, st_last;

    monrx_fsm #(.W(DATA_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_stb     (frame_stb),
        .rx_byte       (rx_byte),
        .tx_act_n      (tx_act_n),
        .local_tx_busy (local_tx_busy),
        .st_full       (st_full),
        .st_empty      (st_empty),
        .st_last       (st_last),
        .push          (push),
        .pop           (pop),
        .clear         (clear),
        .ack_n         (ack_n),
        .msg_valid     (msg_valid),
        .msg_first     (msg_first),
        .msg_last      (msg_last),
        .abort_pulse   (abort_pulse)
    );

    monrx_store #(.W(DATA_W), .DEPTH(STORE_DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .push      (push),
        .push_data (rx_byte),
        .pop       (pop),
        .head      (msg_data),
        .full      (st_full),
        .empty     (st_empty),
        .last_one  (st_last)
    );
endmodule

// File: tb/monrx_lastlook_tb.sv
`timescale 1ns/1ps
module monrx_lastlook_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_stb = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       tx_act_n = 1'b1;
    logic       local_tx_busy = 1'b0;
    logic       ack_n, msg_valid, msg_first, msg_last, abort_pulse;
    logic [7:0] msg_data;

    int checks = 0;
    int errors = 0;
    int log_n = 0;
    int abort_n = 0;
    logic [7:0] log_data [16];
    logic       log_first [16];
    logic       log_last [16];

    always #2.5 clk = ~clk;

    monrx_lastlook #(.DATA_W(8), .STORE_DEPTH(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .rx_byte(rx_byte),
        .tx_act_n(tx_act_n), .local_tx_busy(local_tx_busy), .ack_n(ack_n),
        .msg_valid(msg_valid), .msg_data(msg_data), .msg_first(msg_first),
        .msg_last(msg_last), .abort_pulse(abort_pulse)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (msg_valid && log_n < 16) begin
                log_data[log_n]  = msg_data;
                log_first[log_n] = msg_first;
                log_last[log_n]  = msg_last;
                log_n = log_n + 1;
            end
            if (abort_pulse) abort_n = abort_n + 1;
        end
    end

    task automatic check(input logic ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic ceq(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        check(act == exp, req, what, act, exp);
    endtask

    task automatic frame(input logic txn, input logic [7:0] b);
        @(negedge clk);
        tx_act_n  = txn;
        rx_byte   = b;
        frame_stb = 1'b1;
        @(negedge clk);
        frame_stb = 1'b0;
        repeat (7) @(negedge clk);
    endtask

    task automatic clr_log();
        log_n = 0;
        abort_n = 0;
    endtask

    task automatic take(input logic [7:0] b);
        frame(1'b0, b);
        frame(1'b0, b);
    endtask

    task automatic t_reset();
        ceq("R1", "ack_n", ack_n, 1);
        ceq("R1", "msg_valid", msg_valid, 0);
        ceq("R1", "abort_pulse", abort_pulse, 0);
    endtask

    task automatic t_basic();
        clr_log();
        frame(1'b0, 8'hA5);
        ceq("R2", "ack after one sample", ack_n, 1);
        frame(1'b0, 8'hA5);
        ceq("R2", "ack after two equal samples", ack_n, 0);
        frame(1'b0, 8'hA5);
        ceq("R4", "ack held on repeat", ack_n, 0);
        tx_act_n = 1'b1;
        rx_byte = 8'h3C;
        repeat (6) @(negedge clk);
        ceq("R11", "ack without strobe", ack_n, 0);
        frame(1'b1, 8'h00);
        ceq("R4", "ack released on idle flag", ack_n, 1);
        ceq("R5", "no output after one idle frame", log_n, 0);
        frame(1'b1, 8'h00);
        ceq("R6", "bytes out", log_n, 1);
        ceq("R6", "byte value", log_data[0], 8'hA5);
        ceq("R6", "first marker", log_first[0], 1);
        ceq("R6", "last marker", log_last[0], 1);
        ceq("R7", "no abort", abort_n, 0);
    endtask

    task automatic t_mismatch();
        clr_log();
        frame(1'b0, 8'h11);
        frame(1'b0, 8'h22);
        ceq("R3", "differing pair", ack_n, 1);
        frame(1'b0, 8'h33);
        ceq("R3", "differing again", ack_n, 1);
        frame(1'b0, 8'h33);
        ceq("R3", "equal pair after mismatches", ack_n, 0);
        frame(1'b0, 8'h44);
        ceq("R4", "ack released on new value", ack_n, 1);
        frame(1'b0, 8'h44);
        ceq("R4", "new value counted as first sample", ack_n, 0);
        frame(1'b1, 8'h00);
        take(8'h55);
        ceq("R5", "message open after single gap", ack_n, 0);
        frame(1'b1, 8'h00);
        frame(1'b1, 8'h00);
        ceq("R6", "bytes out", log_n, 3);
        ceq("R6", "byte 0", log_data[0], 8'h33);
        ceq("R6", "byte 1", log_data[1], 8'h44);
        ceq("R6", "byte 2", log_data[2], 8'h55);
        ceq("R6", "first marks", {log_first[0], log_first[1], log_first[2]}, 3'b100);
        ceq("R6", "last marks", {log_last[0], log_last[1], log_last[2]}, 3'b001);
    endtask

    task automatic t_abort_drop();
        clr_log();
        take(8'h10);
        take(8'h20);
        frame(1'b0, 8'h30);
        frame(1'b1, 8'h00);
        ceq("R7", "abort pulses", abort_n, 1);
        ceq("R7", "ack after abort", ack_n, 1);
        frame(1'b1, 8'h00);
        frame(1'b1, 8'h00);
        ceq("R8", "nothing released after abort", log_n, 0);
        take(8'h77);
        frame(1'b1, 8'h00);
        frame(1'b1, 8'h00);
        ceq("R8", "only new message out", log_n, 1);
        ceq("R8", "new byte", log_data[0], 8'h77);
        ceq("R8", "first on new byte", log_first[0], 1);
    endtask

    task automatic t_busy();
        clr_log();
        local_tx_busy = 1'b1;
        frame(1'b0, 8'h66);
        ceq("R9", "no ack while busy", ack_n, 1);
        frame(1'b0, 8'h66);
        ceq("R9", "still no ack", ack_n, 1);
        ceq("R9", "abort raised", abort_n, 1);
        local_tx_busy = 1'b0;
        frame(1'b1, 8'h00);
        frame(1'b1, 8'h00);
        ceq("R9", "nothing out", log_n, 0);
    endtask

    task automatic t_full();
        clr_log();
        for (int i = 1; i <= 4; i++) take(8'(i));
        ceq("R10", "fourth byte acked", ack_n, 0);
        frame(1'b0, 8'h05);
        ceq("R10", "fifth byte refused", ack_n, 1);
        frame(1'b0, 8'h05);
        ceq("R10", "still refused", ack_n, 1);
        ceq("R10", "abort on overflow", abort_n, 1);
        frame(1'b1, 8'h00);
        frame(1'b1, 8'h00);
        ceq("R10", "nothing out", log_n, 0);
    endtask

    task automatic t_idle();
        clr_log();
        frame(1'b1, 8'hFF);
        frame(1'b1, 8'hFF);
        frame(1'b1, 8'hFF);
        ceq("R5", "idle output", log_n, 0);
        ceq("R5", "idle abort", abort_n, 0);
        ceq("R5", "idle ack", ack_n, 1);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not end, actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_mismatch();
        t_abort_drop();
        t_busy();
        t_full();
        t_idle();
        finish_run();
    end
endmodule